// File: doc/BRIEF.md
# Interrupt Stacking and Return Bus Sequencer

This block drives the bus, one cycle at a time, for the two exception paths of a small 8-bit processor core with a 16-bit address space. It is a slave of the core's control unit. Decode, the ALU and the choice of vector number stay in the core. The core gives the block the live register values and the vector location, then raises one of two single-cycle start pulses.

On an entry request the block first makes a dummy read. It then pushes the return address (the program counter minus one) onto a byte-wide stack that grows downward, low byte first, followed by the index register, the accumulator and the condition-code register. It then sets the interrupt mask bit, reads a two-byte vector and fetches the first opcode at the address the vector gives. On a return request it runs the mirror image. It makes a dummy read, pops the five bytes in ascending address order, and restores the condition codes, accumulator, index register and program counter. It then fetches an opcode and an operand from the restored address. The block keeps its own copies of the stack pointer, program counter, index, accumulator and condition codes, and shows them on its outputs for the core to take back.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, busy and bus_valid are 0, sp_out is 16'h00FF, pc_out is 0 and ccr_out is 8'h08, which means the interrupt mask bit (bit 3) is set.
- R2: An accepted entry request makes bus_valid=1 and busy=1 on the next cycle, with a read (bus_read=1) at the captured stack pointer SP. This dummy cycle comes before any write.
- R3: The five entry cycles that follow are writes (bus_read=0). They put (PC-1)[7:0] at SP, (PC-1)[15:8] at SP-1, X at SP-2, A at SP-3 and CCR at SP-4, where all values are the ones captured at the start pulse.
- R4: After the stack writes, entry reads the vector high byte at VEC, then the low byte at VEC+1. The next cycle is an opcode read at {high, low}, and pc_out then holds that address.
- R5: Entry leaves bit 3 of ccr_out set. The CCR byte written to the stack is the value from before the mask was set.
- R6: Each entry stack write lowers sp_out by one, so entry ends with sp_out equal to SP-5.
- R7: An accepted return request gives a dummy read at the captured SP, then reads at SP+1 to SP+5. These restore CCR, A, X, PC high byte and PC low byte, in that order.
- R8: After the return reads, the block fetches the opcode at the restored PC and the operand at PC+1. sp_out ends at SP+5.
- R9: busy is high from the cycle after an accepted start through the last cycle of the sequence: 8 cycles for entry and 6 for return. busy is low during the opcode fetch.
- R10: A start pulse of either kind that arrives while busy is high is ignored, and the bus trace is unchanged.
- R11: If both start pulses arrive in the same cycle while the block is not busy, the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_go | input | 1 | Single-cycle request to start interrupt entry |
| return_go | input | 1 | Single-cycle request to start return from interrupt |
| pc_in | input | 16 | Current program counter, captured at entry start |
| sp_in | input | 16 | Current stack pointer, captured at either start |
| x_in | input | 8 | Index register, captured at entry start |
| a_in | input | 8 | Accumulator, captured at entry start |
| ccr_in | input | 8 | Condition codes, captured at entry start |
| vec_in | input | 16 | Address of the vector high byte, captured at entry start |
| bus_rdata | input | 8 | Read data for the current bus cycle |
| bus_addr | output | 16 | Address of the current bus cycle |
| bus_wdata | output | 8 | Write data, zero on reads |
| bus_read | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_valid | output | 1 | A bus cycle is being driven |
| busy | output | 1 | Sequence in progress |
| pc_out | output | 16 | Program counter held by the block |
| sp_out | output | 16 | Stack pointer held by the block |
| x_out | output | 8 | Index register held by the block |
| a_out | output | 8 | Accumulator held by the block |
| ccr_out | output | 8 | Condition codes held by the block |

## Verification
A wrong step state shows at once on the address bus. The cycle right after the fault has the wrong address or direction, so comparing the trace cycle by cycle finds it within one cycle. A stack pointer that is off by one also shows on the next stack cycle's address. A wrong byte order or a stale captured value shows only as bytes in the wrong stack slots. That fault comes out later, when the following return sequence restores registers that differ from the values entry saved. For this reason every random entry is paired with a return, and the restored registers are compared with the originals.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PUSH_BYTES = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_E_DUMMY,
    ST_E_PCL,
    ST_E_PCH,
    ST_E_X,
    ST_E_A,
    ST_E_CCR,
    ST_E_VH,
    ST_E_VL,
    ST_F_VEC,
    ST_R_DUMMY,
    ST_R_CCR,
    ST_R_A,
    ST_R_X,
    ST_R_PCH,
    ST_R_PCL,
    ST_F_OPC,
    ST_F_OPD
  } seq_state_t;

  // address pushed as the resume point
  function automatic addr_t stacked_pc(input addr_t pc);
    return pc - addr_t'(1);
  endfunction

  function automatic byte_t hi_byte(input addr_t v);
    return v[ADDR_W-1:DATA_W];
  endfunction

  function automatic byte_t lo_byte(input addr_t v);
    return v[DATA_W-1:0];
  endfunction

  // pre-increment pop address
  function automatic addr_t pop_addr(input addr_t sp);
    return sp + addr_t'(1);
  endfunction

  function automatic byte_t with_mask(input byte_t c, input int bit_idx);
    return c | (byte_t'(1) << bit_idx);
  endfunction

  function automatic logic is_entry_step(input seq_state_t s);
    return (s inside {ST_E_DUMMY, ST_E_PCL, ST_E_PCH, ST_E_X, ST_E_A,
                      ST_E_CCR, ST_E_VH, ST_E_VL});
  endfunction

  function automatic logic is_return_step(input seq_state_t s);
    return (s inside {ST_R_DUMMY, ST_R_CCR, ST_R_A, ST_R_X, ST_R_PCH, ST_R_PCL});
  endfunction

  function automatic logic is_push_step(input seq_state_t s);
    return (s inside {ST_E_PCL, ST_E_PCH, ST_E_X, ST_E_A, ST_E_CCR});
  endfunction

  function automatic logic is_pop_step(input seq_state_t s);
    return (s inside {ST_R_CCR, ST_R_A, ST_R_X, ST_R_PCH, ST_R_PCL});
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_go,
  input  logic       return_go,
  output seq_state_t state,
  output logic       busy,
  output logic       accept_entry,
  output logic       accept_return,
  output logic       in_entry,
  output logic       in_return
);

  seq_state_t state_nx;

  assign in_entry      = is_entry_step(state);
  assign in_return     = is_return_step(state);
  assign busy          = in_entry | in_return;
  assign accept_entry  = entry_go & ~busy;
  assign accept_return = return_go & ~entry_go & ~busy;

  function automatic seq_state_t advance(input seq_state_t s);
    case (s)
      ST_E_DUMMY: return ST_E_PCL;
      ST_E_PCL:   return ST_E_PCH;
      ST_E_PCH:   return ST_E_X;
      ST_E_X:     return ST_E_A;
      ST_E_A:     return ST_E_CCR;
      ST_E_CCR:   return ST_E_VH;
      ST_E_VH:    return ST_E_VL;
      ST_E_VL:    return ST_F_VEC;
      ST_R_DUMMY: return ST_R_CCR;
      ST_R_CCR:   return ST_R_A;
      ST_R_A:     return ST_R_X;
      ST_R_X:     return ST_R_PCH;
      ST_R_PCH:   return ST_R_PCL;
      ST_R_PCL:   return ST_F_OPC;
      ST_F_OPC:   return ST_F_OPD;
      default:    return ST_IDLE;
    endcase
  endfunction

  always_comb begin
    if (accept_entry)       state_nx = ST_E_DUMMY;
    else if (accept_return) state_nx = ST_R_DUMMY;
    else                    state_nx = advance(state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/seq_regs.sv
module seq_regs
  import irq_seq_pkg::*;
#(
  parameter addr_t RST_SP    = 16'h00FF,
  parameter int    IMASK_BIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state,
  input  logic       accept_entry,
  input  logic       accept_return,
  input  addr_t      pc_in,
  input  addr_t      sp_in,
  input  byte_t      x_in,
  input  byte_t      a_in,
  input  byte_t      ccr_in,
  input  addr_t      vec_in,
  input  byte_t      rdata,
  output addr_t      pc_q,
  output addr_t      sp_q,
  output byte_t      x_q,
  output byte_t      a_q,
  output byte_t      ccr_q,
  output addr_t      vec_q
);

  localparam byte_t RST_CCR = with_mask('0, IMASK_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= RST_SP;
      x_q   <= '0;
      a_q   <= '0;
      ccr_q <= RST_CCR;
      vec_q <= '0;
    end else if (accept_entry) begin
      pc_q  <= pc_in;
      sp_q  <= sp_in;
      x_q   <= x_in;
      a_q   <= a_in;
      ccr_q <= ccr_in;
      vec_q <= vec_in;
    end else if (accept_return) begin
      sp_q <= sp_in;
    end else begin
      if (is_push_step(state)) sp_q <= sp_q - addr_t'(1);
      if (is_pop_step(state))  sp_q <= pop_addr(sp_q);
      case (state)
        ST_E_CCR: ccr_q <= with_mask(ccr_q, IMASK_BIT);
        ST_E_VH:  pc_q[ADDR_W-1:DATA_W] <= rdata;
        ST_E_VL:  pc_q[DATA_W-1:0]      <= rdata;
        ST_R_CCR: ccr_q <= rdata;
        ST_R_A:   a_q   <= rdata;
        ST_R_X:   x_q   <= rdata;
        ST_R_PCH: pc_q[ADDR_W-1:DATA_W] <= rdata;
        ST_R_PCL: pc_q[DATA_W-1:0]      <= rdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/seq_bus.sv
module seq_bus
  import irq_seq_pkg::*;
(
  input  seq_state_t state,
  input  addr_t      pc_q,
  input  addr_t      sp_q,
  input  byte_t      x_q,
  input  byte_t      a_q,
  input  byte_t      ccr_q,
  input  addr_t      vec_q,
  output addr_t      bus_addr,
  output byte_t      bus_wdata,
  output logic       bus_read,
  output logic       bus_valid
);

  addr_t ret_pc;
  assign ret_pc = stacked_pc(pc_q);

  always_comb begin
    bus_addr  = pc_q;
    bus_wdata = '0;
    bus_read  = 1'b1;
    bus_valid = 1'b1;
    case (state)
      ST_E_DUMMY, ST_R_DUMMY: bus_addr = sp_q;
      ST_E_PCL: begin bus_addr = sp_q; bus_read = 1'b0; bus_wdata = lo_byte(ret_pc); end
      ST_E_PCH: begin bus_addr = sp_q; bus_read = 1'b0; bus_wdata = hi_byte(ret_pc); end
      ST_E_X:   begin bus_addr = sp_q; bus_read = 1'b0; bus_wdata = x_q; end
      ST_E_A:   begin bus_addr = sp_q; bus_read = 1'b0; bus_wdata = a_q; end
      ST_E_CCR: begin bus_addr = sp_q; bus_read = 1'b0; bus_wdata = ccr_q; end
      ST_E_VH:  bus_addr = vec_q;
      ST_E_VL:  bus_addr = vec_q + addr_t'(1);
      ST_R_CCR, ST_R_A, ST_R_X, ST_R_PCH, ST_R_PCL: bus_addr = pop_addr(sp_q);
      ST_F_VEC, ST_F_OPC: bus_addr = pc_q;
      ST_F_OPD: bus_addr = pc_q + addr_t'(1);
      default:  bus_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter logic [15:0] RST_SP    = 16'h00FF,
  parameter int          IMASK_BIT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        entry_go,
  input  logic        return_go,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic [7:0]  x_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  ccr_in,
  input  logic [15:0] vec_in,
  input  logic [7:0]  bus_rdata,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        bus_read,
  output logic        bus_valid,
  output logic        busy,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic [7:0]  x_out,
  output logic [7:0]  a_out,
  output logic [7:0]  ccr_out
);

  seq_state_t state;
  logic accept_entry, accept_return;
  logic in_entry, in_return;
  logic vec_fetch;
  addr_t vec_q;

  assign vec_fetch = (state == ST_F_VEC);

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .entry_go(entry_go), .return_go(return_go),
    .state(state), .busy(busy),
    .accept_entry(accept_entry), .accept_return(accept_return),
    .in_entry(in_entry), .in_return(in_return)
  );

  seq_regs #(.RST_SP(RST_SP), .IMASK_BIT(IMASK_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .state(state),
    .accept_entry(accept_entry), .accept_return(accept_return),
    .pc_in(pc_in), .sp_in(sp_in), .x_in(x_in), .a_in(a_in),
    .ccr_in(ccr_in), .vec_in(vec_in), .rdata(bus_rdata),
    .pc_q(pc_out), .sp_q(sp_out), .x_q(x_out), .a_q(a_out),
    .ccr_q(ccr_out), .vec_q(vec_q)
  );

  seq_bus u_bus (
    .state(state), .pc_q(pc_out), .sp_q(sp_out), .x_q(x_out),
    .a_q(a_out), .ccr_q(ccr_out), .vec_q(vec_q),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_read(bus_read), .bus_valid(bus_valid)
  );

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
  parameter int IMASK_BIT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        entry_go,
  input logic        return_go,
  input logic        busy,
  input logic        bus_valid,
  input logic        bus_read,
  input logic [15:0] bus_addr,
  input logic [15:0] sp_out,
  input logic [7:0]  ccr_out,
  input logic        in_entry,
  input logic        in_return,
  input logic        vec_fetch
);

  AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_read && bus_addr == sp_out)); // R2
  AST_WRITE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_read) |-> in_entry); // R3
  AST_MASK_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> ccr_out[IMASK_BIT]); // R5
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_read) |=> (sp_out == $past(sp_out) - 16'd1)); // R6
  AST_RET_READS: assert property (@(posedge clk) disable iff (!rst_n)
    in_return |-> bus_read); // R7
  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_return && bus_addr != sp_out) |=> (sp_out == $past(sp_out) + 16'd1)); // R8
  AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bus_valid); // R9
  AST_IGNORE_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_entry && return_go) |=> !in_return); // R10
  AST_IGNORE_ENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_return && entry_go) |=> !in_entry); // R10
  AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && entry_go && return_go) |=> in_entry); // R11

endmodule

bind irq_stack_seq irq_stack_seq_chk #(.IMASK_BIT(IMASK_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_go(entry_go), .return_go(return_go),
  .busy(busy), .bus_valid(bus_valid), .bus_read(bus_read),
  .bus_addr(bus_addr), .sp_out(sp_out), .ccr_out(ccr_out),
  .in_entry(in_entry), .in_return(in_return), .vec_fetch(vec_fetch)
);

// File: tb/irq_stack_seq_bench.sv
module irq_stack_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry_go, return_go;
  logic [15:0] pc_in, sp_in, vec_in;
  logic [7:0]  x_in, a_in, ccr_in;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_read, bus_valid, busy;
  logic [15:0] pc_out, sp_out;
  logic [7:0]  x_out, a_out, ccr_out;

  int checks = 0;
  int errors = 0;
  int busy_cycles = 0;
  logic [7:0]  mem [logic [15:0]];
  logic [24:0] trace [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_stack_seq u_irq_stack_seq (.*);

  function automatic logic [7:0] rd_model(input logic [15:0] ad);
    if (mem.exists(ad)) return mem[ad];
    return ad[7:0] ^ ad[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [24:0] cyc(input bit rd, input logic [15:0] ad, input logic [7:0] wd);
    return {rd, ad, wd};
  endfunction

  always @(negedge clk) begin
    if (bus_valid) begin
      trace.push_back({bus_read, bus_addr, bus_wdata});
      if (!bus_read) mem[bus_addr] = bus_wdata;
    end
    if (busy) busy_cycles++;
    bus_rdata = rd_model(bus_addr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_cyc(input int idx, input logic [24:0] exp, input string req);
    logic [24:0] act;
    act = (idx < trace.size()) ? trace[idx] : 25'h1FFFFFF;
    chk(act == exp, req, $sformatf("bus cycle %0d", idx), 32'(act), 32'(exp));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic scramble_inputs;
    pc_in = 16'($urandom); sp_in = 16'($urandom); vec_in = 16'($urandom);
    x_in = 8'($urandom); a_in = 8'($urandom); ccr_in = 8'($urandom);
  endtask

  // inj: 0 none, 1 return_go together with start, 2 return_go mid, 3 entry_go mid
  task automatic run_entry(input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] vec,
                           input logic [7:0] x, input logic [7:0] a, input logic [7:0] ccr,
                           input int inj);
    logic [7:0] vh, vl;
    logic [15:0] rp;
    vh = 8'($urandom); vl = 8'($urandom);
    mem[vec] = vh; mem[vec + 16'd1] = vl;
    rp = pc - 16'd1;
    @(negedge clk);
    trace.delete(); busy_cycles = 0;
    pc_in = pc; sp_in = sp; vec_in = vec; x_in = x; a_in = a; ccr_in = ccr;
    entry_go = 1'b1; return_go = (inj == 1);
    @(negedge clk);
    entry_go = 1'b0; return_go = 1'b0;
    scramble_inputs();
    @(negedge clk);
    @(negedge clk);
    if (inj == 2) return_go = 1'b1;
    if (inj == 3) entry_go = 1'b1;
    @(negedge clk);
    entry_go = 1'b0; return_go = 1'b0;
    repeat (10) @(negedge clk);
    chk(trace.size() == 9, (inj == 0) ? "R3" : ((inj == 1) ? "R11" : "R10"),
        "entry cycle count", 32'(trace.size()), 32'd9);
    chk_cyc(0, cyc(1'b1, sp, 8'h00), "R2");
    chk_cyc(1, cyc(1'b0, sp, rp[7:0]), "R3");
    chk_cyc(2, cyc(1'b0, sp - 16'd1, rp[15:8]), "R3");
    chk_cyc(3, cyc(1'b0, sp - 16'd2, x), "R3");
    chk_cyc(4, cyc(1'b0, sp - 16'd3, a), "R3");
    chk_cyc(5, cyc(1'b0, sp - 16'd4, ccr), "R5");
    chk_cyc(6, cyc(1'b1, vec, 8'h00), "R4");
    chk_cyc(7, cyc(1'b1, vec + 16'd1, 8'h00), "R4");
    chk_cyc(8, cyc(1'b1, {vh, vl}, 8'h00), "R4");
    chk(pc_out == {vh, vl}, "R4", "pc after entry", 32'(pc_out), 32'({vh, vl}));
    chk(ccr_out == (ccr | 8'h08), "R5", "ccr after entry", 32'(ccr_out), 32'(ccr | 8'h08));
    chk(sp_out == sp - 16'd5, "R6", "sp after entry", 32'(sp_out), 32'(sp - 16'd5));
    chk(busy_cycles == 8, "R9", "entry busy cycles", 32'(busy_cycles), 32'd8);
  endtask

  // inj: 0 none, 2 entry_go mid-sequence
  task automatic run_return(input logic [15:0] sp, input int inj);
    logic [15:0] rpc;
    logic [7:0] eccr, ea, ex;
    eccr = rd_model(sp + 16'd1); ea = rd_model(sp + 16'd2); ex = rd_model(sp + 16'd3);
    rpc = {rd_model(sp + 16'd4), rd_model(sp + 16'd5)};
    @(negedge clk);
    trace.delete(); busy_cycles = 0;
    scramble_inputs();
    sp_in = sp; return_go = 1'b1;
    @(negedge clk);
    return_go = 1'b0;
    scramble_inputs();
    @(negedge clk);
    @(negedge clk);
    if (inj == 2) entry_go = 1'b1;
    @(negedge clk);
    entry_go = 1'b0;
    repeat (10) @(negedge clk);
    chk(trace.size() == 8, (inj == 0) ? "R7" : "R10", "return cycle count",
        32'(trace.size()), 32'd8);
    chk_cyc(0, cyc(1'b1, sp, 8'h00), "R7");
    for (int i = 1; i <= 5; i++)
      chk_cyc(i, cyc(1'b1, sp + 16'(i), 8'h00), "R7");
    chk_cyc(6, cyc(1'b1, rpc, 8'h00), "R8");
    chk_cyc(7, cyc(1'b1, rpc + 16'd1, 8'h00), "R8");
    chk(ccr_out == eccr, "R7", "restored ccr", 32'(ccr_out), 32'(eccr));
    chk(a_out == ea, "R7", "restored a", 32'(a_out), 32'(ea));
    chk(x_out == ex, "R7", "restored x", 32'(x_out), 32'(ex));
    chk(pc_out == rpc, "R8", "restored pc", 32'(pc_out), 32'(rpc));
    chk(sp_out == sp + 16'd5, "R8", "sp after return", 32'(sp_out), 32'(sp + 16'd5));
    chk(busy_cycles == 6, "R9", "return busy cycles", 32'(busy_cycles), 32'd6);
  endtask

  // one entry followed by its return; registers must come back
  task automatic round_trip(input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] vec,
                            input logic [7:0] x, input logic [7:0] a, input logic [7:0] ccr,
                            input int einj, input int rinj);
    run_entry(pc, sp, vec, x, a, ccr, einj);
    run_return(sp - 16'd5, rinj);
    chk(ccr_out == ccr, "R7", "round-trip ccr", 32'(ccr_out), 32'(ccr));
    chk(pc_out == pc - 16'd1, "R8", "round-trip pc", 32'(pc_out), 32'(pc - 16'd1));
    chk(sp_out == sp, "R8", "round-trip sp", 32'(sp_out), 32'(sp));
    chk({x_out, a_out} == {x, a}, "R7", "round-trip x,a", 32'({x_out, a_out}), 32'({x, a}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; entry_go = 1'b0; return_go = 1'b0;
    pc_in = '0; sp_in = '0; vec_in = '0; x_in = '0; a_in = '0; ccr_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && bus_valid == 1'b0, "R1", "busy/valid after reset",
        32'({busy, bus_valid}), 32'd0);
    chk(sp_out == 16'h00FF, "R1", "sp after reset", 32'(sp_out), 32'h00FF);
    chk(pc_out == 16'h0000, "R1", "pc after reset", 32'(pc_out), 32'h0);
    chk(ccr_out == 8'h08, "R1", "ccr after reset", 32'(ccr_out), 32'h08);

    // directed corners
    round_trip(16'h0000, 16'h0002, 16'hFFF0, 8'h11, 8'h22, 8'h00, 0, 0);
    round_trip(16'h8001, 16'h0100, 16'hFFF2, 8'hFF, 8'h00, 8'hF7, 1, 0);
    round_trip(16'h1234, 16'h00FF, 16'hFFF4, 8'h5A, 8'hA5, 8'h08, 2, 2);
    round_trip(16'hFFFF, 16'h7FFF, 16'hFFF6, 8'h01, 8'h80, 8'h35, 3, 2);

    for (int it = 0; it < 24; it++) begin
      logic [15:0] rpc, rsp, rvec;
      rpc  = 16'($urandom);
      rsp  = 16'h0200 + 16'($urandom_range(0, 16'h3FFF));
      rvec = 16'hFF00 + 16'({$urandom_range(0, 119), 1'b0});
      round_trip(rpc, rsp, rvec, 8'($urandom), 8'($urandom), 8'($urandom),
                 it % 4, (it % 3 == 0) ? 2 : 0);
    end
    finish_run();
  end

endmodule